// File: doc/BRIEF.md
# Instance Memory Address Translator

This unit maps a byte address in the instance-memory space (the control-structure area that sits at the top of video memory) onto a physical video-memory address. In single-buffer operation, 32-bit words are laid out downward from the highest word of memory. In double-buffer operation, consecutive 256-byte chunks alternate between the upper and lower halves of memory, starting in the upper half. The memory size comes from a 2-bit size code.

Alongside the physical address, the unit reports which fixed control region the untranslated instance address belongs to. A 2-bit layout code selects one of four region maps. Addresses past the last fixed region are flagged as belonging to the general object area. One of the four layouts has a context region that collides with the hash table, and the unit marks every access that decodes to that region under that layout.

Results are registered. A request is accepted with a valid/ready handshake and its result appears one cycle later. The result is held while the consumer stalls.

Top module: `imem_translator`

## Requirements
- R1: With `dbl_en`=0, every address bit above bit 1 is inverted, using the full 22-bit physical width, and the result is masked to the memory size. Equivalently, `out_phys` = size − 4·(addr>>2) − 4 + (addr & 3).
- R2: Size code 0 selects 1 MB, code 1 selects 2 MB, and codes 2 and 3 both select 4 MB.
- R3: With `dbl_en`=1, instance bit 8 equal to 0 places the result in the upper half of memory, and bit 8 equal to 1 places it in the lower half. Instance address 0 therefore maps to size − 4.
- R4: With `dbl_en`=1, the offset within the half is built from the inverted address. The low 8 bits stay in place, the inverted bits from 9 upward move down to start at bit 8, and the result is masked to half the memory size. Equivalently, the offset is (half/256 − 1 − (addr>>9))·256 + 252 − (addr & 252) + (addr & 3).
- R5: Bits 1:0 of `out_phys` always equal bits 1:0 of the instance address.
- R6: `out_region` encodes the region as 0 hash table, 1 runout, 2 channel context, 3 audio, 4 spare, 5 object area. The region is decoded from the untranslated address against the start addresses of regions 1 to 5 for the selected layout:
  - layout 0: 0x1000, 0x1800, 0x2000, 0x2C00, 0x3000
  - layout 1: 0x2000, 0x3000, 0x4000, 0x4C00, 0x5000
  - layout 2: 0x2000, 0x6000, 0x8000, 0x8C00, 0x9000
  - layout 3: 0x8000, 0xC000, 0x10000, 0x10C00, 0x11000
- R7: An address at or above the layout's end boundary yields region 5 with `out_free`=1. Every other address yields `out_free`=0.
- R8: `out_faulty` is 1 exactly when the layout code is 2 and the region is 2.
- R9: A request accepted on a clock edge (`in_valid` and `in_ready` both high) makes `out_valid` high after that edge, carrying that request's result.
- R10: While `out_valid` is high and `out_ready` is low, all outputs hold their values and `in_ready` is low. When `out_ready` rises, a waiting request is accepted on the same edge that the held result is consumed.
- R11: During reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken |
| in_addr | input | 20 | Instance-memory byte address |
| size_code | input | 2 | Video memory size selector |
| dbl_en | input | 1 | Double-buffer mode enable |
| layout | input | 2 | Fixed region layout selector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_phys | output | 22 | Physical video-memory byte address |
| out_region | output | 3 | Region code |
| out_free | output | 1 | Address lies beyond every fixed region |
| out_faulty | output | 1 | Access falls in the colliding context region |

## Verification
The bench builds the block with its default widths: a 20-bit instance address and a 22-bit physical address. At these widths all four size codes, including the aliased code 3, both buffer modes and all four layouts can be swept completely, giving 32 configurations. In each configuration the bench drives every region boundary and the byte just below it, together with the chunk edges around bit 8 and bit 9, the top of the instance space, and a coarse stride across the full megabyte. This covers both halves in every double-buffer case and every transition between regions. A separate stall sequence exercises the hold behaviour and the simultaneous consume-and-accept edge.

// File: rtl/imem_pkg.sv
package imem_pkg;

  localparam int INST_W       = 20;
  localparam int MEM_LOG2_MIN = 20;
  localparam int SIZE_STEPS   = 2;
  localparam int PA_W         = MEM_LOG2_MIN + SIZE_STEPS;
  localparam int CHUNK_LOG2   = 8;
  localparam int NUM_BOUND    = 5;
  localparam int REG_W        = 3;

  typedef enum logic [REG_W-1:0] {
    REG_HASH   = 3'd0,
    REG_RUNOUT = 3'd1,
    REG_CTX    = 3'd2,
    REG_AUDIO  = 3'd3,
    REG_SPARE  = 3'd4,
    REG_OBJECT = 3'd5
  } region_e;

  typedef struct packed {
    logic [PA_W-1:0] phys;
    region_e         region;
    logic            free;
    logic            faulty;
  } xl_result_t;

  // log2 of the memory size in bytes; codes past the largest alias to it
  function automatic int size_log(input logic [1:0] code);
    int step;
    step = (int'(code) > SIZE_STEPS) ? SIZE_STEPS : int'(code);
    return MEM_LOG2_MIN + step;
  endfunction

  // start address of region k (1..NUM_BOUND, the last being the end mark)
  function automatic logic [INST_W-1:0] bound(input logic [1:0] lay, input int k);
    logic [INST_W-1:0] b;
    b = '0;
    case (lay)
      2'd0: case (k)
        1: b = 20'h01000; 2: b = 20'h01800; 3: b = 20'h02000;
        4: b = 20'h02C00; default: b = 20'h03000;
      endcase
      2'd1: case (k)
        1: b = 20'h02000; 2: b = 20'h03000; 3: b = 20'h04000;
        4: b = 20'h04C00; default: b = 20'h05000;
      endcase
      2'd2: case (k)
        1: b = 20'h02000; 2: b = 20'h06000; 3: b = 20'h08000;
        4: b = 20'h08C00; default: b = 20'h09000;
      endcase
      default: case (k)
        1: b = 20'h08000; 2: b = 20'h0C000; 3: b = 20'h10000;
        4: b = 20'h10C00; default: b = 20'h11000;
      endcase
    endcase
    return b;
  endfunction

endpackage

// File: rtl/imem_xlate.sv
module imem_xlate
  import imem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INST_W-1:0] addr,
  input  logic [1:0]        size_code,
  input  logic              dbl,
  output logic [PA_W-1:0]   phys
);

  int              slog;
  logic [PA_W-1:0] inv;
  logic [PA_W-1:0] full_mask;
  logic [PA_W-1:0] half_mask;
  logic [PA_W-1:0] folded;
  logic            upper_half;

  always_comb begin
    slog       = size_log(size_code);
    inv        = PA_W'(addr) ^ ~PA_W'(3);
    full_mask  = {PA_W{1'b1}} >> (PA_W - slog);
    half_mask  = full_mask >> 1;
    upper_half = inv[CHUNK_LOG2];
    folded     = {1'b0, inv[PA_W-1:CHUNK_LOG2+1], inv[CHUNK_LOG2-1:0]};
    if (dbl)
      phys = (folded & half_mask) | (upper_half ? (full_mask & ~half_mask) : '0);
    else
      phys = inv & full_mask;
  end

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    phys[1:0] == addr[1:0]);  // R5

  AST_HALF_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    dbl |-> ((phys >> (slog - 1)) == PA_W'(!addr[CHUNK_LOG2])));  // R3

  AST_IN_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (phys >> slog) == '0);  // R2

endmodule

// File: rtl/imem_region.sv
module imem_region
  import imem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [INST_W-1:0] addr,
  input  logic [1:0]        layout,
  output region_e           region,
  output logic              free,
  output logic              faulty
);

  logic [NUM_BOUND:1] at_or_above;
  logic [NUM_BOUND:0] hit;

  for (genvar k = 1; k <= NUM_BOUND; k++) begin : g_cmp
    assign at_or_above[k] = addr >= bound(layout, k);
  end

  for (genvar k = 0; k <= NUM_BOUND; k++) begin : g_hit
    if (k == 0) begin : g_first
      assign hit[k] = !at_or_above[1];
    end else if (k == NUM_BOUND) begin : g_last
      assign hit[k] = at_or_above[k];
    end else begin : g_mid
      assign hit[k] = at_or_above[k] && !at_or_above[k+1];
    end
  end

  // lowest-numbered matching region wins
  always_comb begin
    region = REG_OBJECT;
    for (int k = NUM_BOUND; k >= 0; k--)
      if (hit[k]) region = region_e'(REG_W'(k));
  end

  assign free   = at_or_above[NUM_BOUND];
  assign faulty = (layout == 2'd2) && hit[REG_CTX];

  AST_ONE_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(hit) == 1);  // R6

  AST_FREE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    free |-> region == REG_OBJECT);  // R7

endmodule

// File: rtl/imem_stage.sv
module imem_stage
  import imem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  xl_result_t d,
  output logic       out_valid,
  input  logic       out_ready,
  output xl_result_t q
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)
      out_valid <= 1'b0;
    else if (in_ready)
      out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (in_valid && in_ready)
      q <= d;
  end

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);  // R9

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(q));  // R10

endmodule

// File: rtl/imem_translator.sv
module imem_translator
  import imem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [INST_W-1:0] in_addr,
  input  logic [1:0]        size_code,
  input  logic              dbl_en,
  input  logic [1:0]        layout,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PA_W-1:0]   out_phys,
  output logic [REG_W-1:0]  out_region,
  output logic              out_free,
  output logic              out_faulty
);

  xl_result_t next_res;
  xl_result_t held_res;

  imem_xlate u_xlate (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (in_addr),
    .size_code (size_code),
    .dbl       (dbl_en),
    .phys      (next_res.phys)
  );

  imem_region u_region (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr   (in_addr),
    .layout (layout),
    .region (next_res.region),
    .free   (next_res.free),
    .faulty (next_res.faulty)
  );

  imem_stage u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .d         (next_res),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .q         (held_res)
  );

  assign out_phys   = held_res.phys;
  assign out_region = held_res.region;
  assign out_free   = held_res.free;
  assign out_faulty = held_res.faulty;

  AST_FAULT_IN_CTX: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_faulty |-> out_region == REG_CTX);  // R8

  AST_FREE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_free == (out_region == REG_OBJECT));  // R7

  AST_STALL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);  // R10

endmodule

// File: tb/test_imem_translator.sv
module test_imem_translator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [19:0] in_addr = '0;
  logic [1:0]  size_code = '0;
  logic        dbl_en = 1'b0;
  logic [1:0]  layout = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [21:0] out_phys;
  logic [2:0]  out_region;
  logic        out_free;
  logic        out_faulty;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  imem_translator i_imem_translator (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .size_code(size_code), .dbl_en(dbl_en), .layout(layout),
    .out_valid(out_valid), .out_ready(out_ready), .out_phys(out_phys),
    .out_region(out_region), .out_free(out_free), .out_faulty(out_faulty)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic longint mem_bytes(input int sz);
    return longint'(1) << (20 + ((sz > 2) ? 2 : sz));
  endfunction

  function automatic longint exp_phys(input int a, input int sz, input bit dbl);
    longint size, half, chunks, b;
    size = mem_bytes(sz);
    if (!dbl) return size - 4 * ((a >> 2) + 1) + (a & 3);
    half   = size / 2;
    chunks = half / 256;
    b      = a & 255;
    return (((a >> 8) & 1) != 0 ? 0 : half) + (chunks - 1 - (a >> 9)) * 256
           + 252 - (b & 252) + (b & 3);
  endfunction

  function automatic int exp_region(input int a, input int lay);
    int edges[5];
    int r;
    case (lay)
      0: edges = '{'h1000, 'h1800, 'h2000, 'h2C00, 'h3000};
      1: edges = '{'h2000, 'h3000, 'h4000, 'h4C00, 'h5000};
      2: edges = '{'h2000, 'h6000, 'h8000, 'h8C00, 'h9000};
      default: edges = '{'h8000, 'hC000, 'h10000, 'h10C00, 'h11000};
    endcase
    r = 0;
    for (int k = 0; k < 5; k++) if (a >= edges[k]) r = k + 1;
    return r;
  endfunction

  task automatic xfer(input int a, input int sz, input bit dbl, input int lay);
    int r;
    @(negedge clk);
    in_addr = 20'(a); size_code = 2'(sz); dbl_en = dbl; layout = 2'(lay);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    r = exp_region(a, lay);
    chk("R9", "out_valid", longint'(out_valid), 1);
    if (dbl) chk("R3 R4", "phys dbl", longint'(out_phys), exp_phys(a, sz, dbl));
    else     chk("R1 R2", "phys single", longint'(out_phys), exp_phys(a, sz, dbl));
    chk("R5", "low bits", longint'(out_phys[1:0]), longint'(a & 3));
    chk("R6", "region", longint'(out_region), longint'(r));
    chk("R7", "free", longint'(out_free), longint'(r == 5));
    chk("R8", "faulty", longint'(out_faulty), longint'(lay == 2 && r == 2));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int addrs[$];
    int edge_list[16] = '{'h1000, 'h1800, 'h2000, 'h2C00, 'h3000, 'h4000, 'h4C00,
                          'h5000, 'h6000, 'h8000, 'h8C00, 'h9000, 'hC000, 'h10000,
                          'h10C00, 'h11000};
    longint ea, eb;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", "out_valid in reset", longint'(out_valid), 0);
    chk("R11", "in_ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;

    addrs = '{0, 1, 2, 3, 4, 'hFC, 'hFF, 'h100, 'h101, 'h1FC, 'h1FF, 'h200, 'h2FF,
              'h300, 'hFFFFC, 'hFFFFF, 'h7FFFF, 'h80000};
    foreach (edge_list[i]) begin
      addrs.push_back(edge_list[i] - 1);
      addrs.push_back(edge_list[i]);
    end
    for (int a = 'h137; a < 'h100000; a += 'h4E21) addrs.push_back(a);

    for (int sz = 0; sz < 4; sz++)
      for (int dbl = 0; dbl < 2; dbl++)
        for (int lay = 0; lay < 4; lay++)
          foreach (addrs[i]) xfer(addrs[i], sz, 1'(dbl), lay);

    // R10: stall holds result and blocks input, then consume-and-accept
    ea = exp_phys('h1234, 1, 1'b1);
    eb = exp_phys('h5678, 1, 1'b1);
    @(negedge clk);
    out_ready = 1'b0;
    in_addr = 20'h01234; size_code = 2'd1; dbl_en = 1'b1; layout = 2'd0;
    in_valid = 1'b1;
    @(negedge clk);
    in_addr = 20'h05678;
    chk("R9", "stall out_valid", longint'(out_valid), 1);
    chk("R10", "stall in_ready", longint'(in_ready), 0);
    chk("R10", "stall phys first", longint'(out_phys), ea);
    repeat (2) @(negedge clk);
    chk("R10", "stall phys held", longint'(out_phys), ea);
    chk("R10", "stall region held", longint'(out_region), 1);
    chk("R10", "stall in_ready held", longint'(in_ready), 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R10", "second accepted", longint'(out_valid), 1);
    chk("R10", "second phys", longint'(out_phys), eb);
    chk("R10", "second region", longint'(out_region), 5);
    @(negedge clk);
    chk("R9", "drained", longint'(out_valid), 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule